// File: doc/BRIEF.md
# PHY Power-Up Initialization Sequencer

This block brings the storage-card PHY out of reset. After a start pulse it runs a fixed script over an indirect register port. Most steps read a PHY register, OR a constant mask into the value and write the result back. Partway through, the script polls the pad status register until pad calibration reports done. The script ends with a plain write that selects legacy bus timing. The block then raises a done flag, or an error flag if any access or the calibration poll runs out of time.

The requester port speaks to an indirect access bridge. The sequencer presents an offset, a write flag and write data for a single cycle, and only while the bridge reports itself idle. An access is complete on the first following cycle in which the bridge is not busy. Read data is taken on that cycle.

Top module: `phy_bringup_seq`

## Requirements
- R1: While reset is held and after it is released, `done`, `err` and `reqValid` are low.
- R2: A `start` pulse seen while the block is idle begins the script from its first step. A `start` seen while the script is running has no effect on the access sequence.
- R3: The script opens with two read-modify-write steps. Offset 0x01 is read and written back ORed with 0x42 (bits 6 and 1). Offset 0x02 is then read and written back ORed with 0x02 (bit 1).
- R4: The block then reads offset 0x03 repeatedly until bit 4 of the read data is set. It never writes offset 0x03.
- R5: After calibration it performs read-modify-write steps in this exact order: 0x06 OR 0x03, 0x08 OR 0x02, 0x20 OR 0x01, 0x07 OR 0xFF, 0x09 OR 0xFF, 0x21 OR 0xFF, 0x22 OR 0x01, 0x23 OR 0x01, 0x0F OR 0x07. Each write-back carries the value just read with the mask ORed in.
- R6: The last access writes 0x04 (legacy timing, bit 2) to offset 0x11 without reading it first. `done` rises only after this write completes.
- R7: A request lasts exactly one cycle and is issued only while `bridgeBusy` is low. The access completes on the first later cycle with `bridgeBusy` low, which may be the very next cycle.
- R8: Each access has a window of TIMEOUT_CYCLES = (CLK_FREQ_HZ/1e6)*TIMEOUT_US cycles, counted from when it becomes due. If the bridge is still busy when the window ends, `err` is set and no further request is made.
- R9: The calibration poll has one window of TIMEOUT_CYCLES that starts with the first status read. If a status read completes without bit 4 after the window has ended, `err` is set and none of the later steps are performed.
- R10: `done` and `err` are sticky until the next accepted `start`, which clears both. They are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the bring-up script (accepted when idle) |
| reqValid | output | 1 | One-cycle access request to the bridge |
| reqWrite | output | 1 | Request is a write (1) or read (0) |
| reqOffset | output | 8 | PHY register offset of the request |
| reqWdata | output | 8 | Write data of the request |
| rspRdata | input | 8 | Read data from the bridge, valid on completion |
| bridgeBusy | input | 1 | Bridge is executing an access |
| done | output | 1 | Script finished successfully (sticky) |
| err | output | 1 | Script aborted on a timeout (sticky) |

## Verification
The bench builds the sequencer with CLK_FREQ_HZ = 8 MHz and TIMEOUT_US = 4, which gives a 32-cycle window. With a window that short, a stuck bridge and a calibration that never finishes both hit their timeouts within a few dozen cycles, and the exact cycle of the error can be bounded. Short bridge latencies of zero, one and two cycles keep the polls inside the window, so the same build also covers the back-to-back completion case and polls of one to three status reads.

// File: rtl/phy_bringup_pkg.sv
`timescale 1ns/1ps
package phy_bringup_pkg;

  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 8;
  localparam int NUM_STEPS = 13;
  localparam int STEP_W    = $clog2(NUM_STEPS + 1);

  typedef enum logic [1:0] {
    STEP_RMW   = 2'd0,
    STEP_POLL  = 2'd1,
    STEP_WRITE = 2'd2
  } stepKind_e;

  typedef struct packed {
    stepKind_e           kind;
    logic [ADDR_W-1:0]   offset;
    logic [DATA_W-1:0]   mask;
  } stepEntry_t;

  // control -> datapath strobes
  typedef struct packed {
    logic clrStep;
    logic incStep;
    logic loadAcc;
    logic loadPoll;
    logic capData;
  } ctrlStrobes_t;

  // datapath -> control status
  typedef struct packed {
    stepKind_e kind;
    logic      lastStep;
    logic      calHit;
    logic      accExpired;
    logic      pollExpired;
  } dpStatus_t;

endpackage

// File: rtl/phy_bringup_dp.sv
`timescale 1ns/1ps
module phy_bringup_dp
  import phy_bringup_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 20000
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strb,
  input  logic [DATA_W-1:0]  rspRdata,
  output dpStatus_t          stat,
  output logic [ADDR_W-1:0]  reqOffset,
  output logic [DATA_W-1:0]  reqWdata,
  output logic [STEP_W-1:0]  stepIdx
);

  localparam int TIMER_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TIMER_W-1:0] TIMER_LOAD = TIMER_W'(TIMEOUT_CYCLES);
  localparam logic [STEP_W-1:0]  LAST_IDX   = STEP_W'(NUM_STEPS);

  // Bring-up script; the order is the behaviour.
  function automatic stepEntry_t stepAt(input logic [STEP_W-1:0] idx);
    stepEntry_t e;
    case (idx)
      4'd0:    e = '{STEP_RMW,   8'h01, 8'h42};
      4'd1:    e = '{STEP_RMW,   8'h02, 8'h02};
      4'd2:    e = '{STEP_POLL,  8'h03, 8'h10};
      4'd3:    e = '{STEP_RMW,   8'h06, 8'h03};
      4'd4:    e = '{STEP_RMW,   8'h08, 8'h02};
      4'd5:    e = '{STEP_RMW,   8'h20, 8'h01};
      4'd6:    e = '{STEP_RMW,   8'h07, 8'hFF};
      4'd7:    e = '{STEP_RMW,   8'h09, 8'hFF};
      4'd8:    e = '{STEP_RMW,   8'h21, 8'hFF};
      4'd9:    e = '{STEP_RMW,   8'h22, 8'h01};
      4'd10:   e = '{STEP_RMW,   8'h23, 8'h01};
      4'd11:   e = '{STEP_RMW,   8'h0F, 8'h07};
      4'd12:   e = '{STEP_WRITE, 8'h11, 8'h04};
      default: e = '{STEP_RMW,   8'h00, 8'h00};
    endcase
    return e;
  endfunction

  stepEntry_t        curStep;
  logic [DATA_W-1:0] dataReg;
  logic [TIMER_W-1:0] accTimer;
  logic [TIMER_W-1:0] pollTimer;

  assign curStep = stepAt(stepIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepIdx <= '0;
    end else if (strb.clrStep) begin
      stepIdx <= '0;
    end else if (strb.incStep && stepIdx != LAST_IDX) begin
      stepIdx <= stepIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg <= '0;
    end else if (strb.capData) begin
      dataReg <= rspRdata | curStep.mask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accTimer <= '0;
    end else if (strb.loadAcc) begin
      accTimer <= TIMER_LOAD;
    end else if (accTimer != '0) begin
      accTimer <= accTimer - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pollTimer <= '0;
    end else if (strb.loadPoll) begin
      pollTimer <= TIMER_LOAD;
    end else if (pollTimer != '0) begin
      pollTimer <= pollTimer - 1'b1;
    end
  end

  assign reqOffset = curStep.offset;
  assign reqWdata  = (curStep.kind == STEP_WRITE) ? curStep.mask : dataReg;

  always_comb begin
    stat             = '0;
    stat.kind        = curStep.kind;
    stat.lastStep    = (stepIdx == LAST_IDX);
    stat.calHit      = |(rspRdata & curStep.mask);
    stat.accExpired  = (accTimer == '0);
    stat.pollExpired = (pollTimer == '0);
  end

  // control never asks to advance beyond the end of the script
  assert_step_in_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.incStep |-> stepIdx != LAST_IDX);

  // a freshly loaded access window is never already expired
  assert_window_loaded_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadAcc |=> accTimer != '0);

endmodule

// File: rtl/phy_bringup_ctrl.sv
`timescale 1ns/1ps
module phy_bringup_ctrl
  import phy_bringup_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         bridgeBusy,
  input  dpStatus_t    stat,
  output ctrlStrobes_t strb,
  output logic         reqValid,
  output logic         reqWrite,
  output logic         done,
  output logic         err
);

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_ISSUE_RD, S_WAIT_RD, S_ISSUE_WR, S_WAIT_WR
  } seqState_e;

  seqState_e state, stateNxt;
  logic setDone, setErr, accept;

  assign accept = (state == S_IDLE) && start;

  always_comb begin
    stateNxt = state;
    strb     = '0;
    reqValid = 1'b0;
    reqWrite = 1'b0;
    setDone  = 1'b0;
    setErr   = 1'b0;
    case (state)
      S_IDLE: begin
        if (start) begin
          strb.clrStep = 1'b1;
          stateNxt     = S_FETCH;
        end
      end
      S_FETCH: begin
        if (stat.lastStep) begin
          setDone  = 1'b1;
          stateNxt = S_IDLE;
        end else begin
          strb.loadAcc = 1'b1;
          case (stat.kind)
            STEP_POLL: begin
              strb.loadPoll = 1'b1;
              stateNxt      = S_ISSUE_RD;
            end
            STEP_WRITE: stateNxt = S_ISSUE_WR;
            default:    stateNxt = S_ISSUE_RD;
          endcase
        end
      end
      S_ISSUE_RD: begin
        if (!bridgeBusy) begin
          reqValid = 1'b1;
          stateNxt = S_WAIT_RD;
        end else if (stat.accExpired) begin
          setErr   = 1'b1;
          stateNxt = S_IDLE;
        end
      end
      S_WAIT_RD: begin
        if (!bridgeBusy) begin
          if (stat.kind == STEP_POLL) begin
            if (stat.calHit) begin
              strb.incStep = 1'b1;
              stateNxt     = S_FETCH;
            end else if (stat.pollExpired) begin
              setErr   = 1'b1;
              stateNxt = S_IDLE;
            end else begin
              strb.loadAcc = 1'b1;
              stateNxt     = S_ISSUE_RD;
            end
          end else begin
            strb.capData = 1'b1;
            strb.loadAcc = 1'b1;
            stateNxt     = S_ISSUE_WR;
          end
        end else if (stat.accExpired) begin
          setErr   = 1'b1;
          stateNxt = S_IDLE;
        end
      end
      S_ISSUE_WR: begin
        if (!bridgeBusy) begin
          reqValid = 1'b1;
          reqWrite = 1'b1;
          stateNxt = S_WAIT_WR;
        end else if (stat.accExpired) begin
          setErr   = 1'b1;
          stateNxt = S_IDLE;
        end
      end
      S_WAIT_WR: begin
        if (!bridgeBusy) begin
          strb.incStep = 1'b1;
          stateNxt     = S_FETCH;
        end else if (stat.accExpired) begin
          setErr   = 1'b1;
          stateNxt = S_IDLE;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      state <= stateNxt;
      if (accept) begin
        done <= 1'b0;
        err  <= 1'b0;
      end else begin
        if (setDone) done <= 1'b1;
        if (setErr)  err  <= 1'b1;
      end
    end
  end

  // a request never spans two cycles
  assert_req_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> !reqValid);

  // the two outcome flags are exclusive
  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(done && err));

endmodule

// File: rtl/phy_bringup_seq.sv
`timescale 1ns/1ps
module phy_bringup_seq
  import phy_bringup_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 200_000_000,
  parameter int TIMEOUT_US  = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              reqValid,
  output logic              reqWrite,
  output logic [ADDR_W-1:0] reqOffset,
  output logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] rspRdata,
  input  logic              bridgeBusy,
  output logic              done,
  output logic              err
);

  localparam int RAW_CYCLES     = (CLK_FREQ_HZ / 1_000_000) * TIMEOUT_US;
  localparam int TIMEOUT_CYCLES = (RAW_CYCLES < 1) ? 1 : RAW_CYCLES;

  ctrlStrobes_t      strb;
  dpStatus_t         stat;
  logic [STEP_W-1:0] stepIdx;

  phy_bringup_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .bridgeBusy (bridgeBusy),
    .stat       (stat),
    .strb       (strb),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .done       (done),
    .err        (err)
  );

  phy_bringup_dp #(
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .rspRdata  (rspRdata),
    .stat      (stat),
    .reqOffset (reqOffset),
    .reqWdata  (reqWdata),
    .stepIdx   (stepIdx)
  );

  assert_done_after_script_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> stepIdx == STEP_W'(NUM_STEPS));

  assert_poll_never_writes_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && stat.kind == STEP_POLL) |-> !reqWrite);

  assert_quiet_after_outcome_R10: assert property (@(posedge clk) disable iff (!rstN)
    (done || err) |-> !reqValid);

endmodule

// File: tb/phy_bringup_seq_tb.sv
`timescale 1ns/1ps
module phy_bringup_seq_tb_top;

  localparam int CLK_HZ   = 8_000_000;
  localparam int TMO_US   = 4;
  localparam int WINDOW   = (CLK_HZ / 1_000_000) * TMO_US;
  localparam int NSTEP    = 13;
  localparam int LOG_MAX  = 256;

  // {kind[1:0], offset[7:0], mask[7:0]}; kind 0 = RMW, 1 = poll, 2 = write only
  localparam logic [17:0] SCRIPT [0:NSTEP-1] = '{
    {2'd0, 8'h01, 8'h42}, {2'd0, 8'h02, 8'h02}, {2'd1, 8'h03, 8'h10},
    {2'd0, 8'h06, 8'h03}, {2'd0, 8'h08, 8'h02}, {2'd0, 8'h20, 8'h01},
    {2'd0, 8'h07, 8'hFF}, {2'd0, 8'h09, 8'hFF}, {2'd0, 8'h21, 8'hFF},
    {2'd0, 8'h22, 8'h01}, {2'd0, 8'h23, 8'h01}, {2'd0, 8'h0F, 8'h07},
    {2'd2, 8'h11, 8'h04}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       reqValid, reqWrite, done, err;
  logic [7:0] reqOffset, reqWdata;
  logic [7:0] rspRdata;
  logic       bridgeBusy;

  int checks = 0;
  int errors = 0;

  // bridge model controls
  int lat = 2;
  bit hang = 1'b0;
  int calAfter = 3;

  logic [7:0] mem [0:63];
  int statusCnt;
  int busyCnt;
  int logCnt;
  logic       logWr   [0:LOG_MAX-1];
  logic [7:0] logOff  [0:LOG_MAX-1];
  logic [7:0] logData [0:LOG_MAX-1];

  int         expCnt;
  logic       expWr   [0:LOG_MAX-1];
  logic [7:0] expOff  [0:LOG_MAX-1];
  logic [7:0] expData [0:LOG_MAX-1];
  string      expTag  [0:LOG_MAX-1];

  always #4 clk = ~clk;

  phy_bringup_seq #(
    .CLK_FREQ_HZ (CLK_HZ),
    .TIMEOUT_US  (TMO_US)
  ) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqOffset  (reqOffset),
    .reqWdata   (reqWdata),
    .rspRdata   (rspRdata),
    .bridgeBusy (bridgeBusy),
    .done       (done),
    .err        (err)
  );

  function automatic logic [7:0] initVal(input int i);
    return 8'((i * 53 + 17) & 255);
  endfunction

  // indirect bridge model with access log
  always @(posedge clk) begin
    if (!rstN) begin
      bridgeBusy <= 1'b0;
      busyCnt    <= 0;
      statusCnt  <= 0;
      logCnt     <= 0;
      rspRdata   <= 8'h00;
      for (int i = 0; i < 64; i++) mem[i] <= initVal(i);
    end else if (reqValid && !bridgeBusy) begin
      if (logCnt < LOG_MAX) begin
        logWr[logCnt]   <= reqWrite;
        logOff[logCnt]  <= reqOffset;
        logData[logCnt] <= reqWdata;
      end
      logCnt <= logCnt + 1;
      if (reqWrite) begin
        mem[reqOffset[5:0]] <= reqWdata;
      end else if (reqOffset == 8'h03) begin
        rspRdata  <= (statusCnt + 1 >= calAfter) ? (mem[3] | 8'h10) : (mem[3] & 8'hEF);
        statusCnt <= statusCnt + 1;
      end else begin
        rspRdata <= mem[reqOffset[5:0]];
      end
      if (hang) begin
        bridgeBusy <= 1'b1;
      end else if (lat > 0) begin
        bridgeBusy <= 1'b1;
        busyCnt    <= lat;
      end
    end else if (bridgeBusy && !hang) begin
      if (busyCnt <= 1) bridgeBusy <= 1'b0;
      busyCnt <= busyCnt - 1;
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulseStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic waitOutcome(output int cycles);
    cycles = 0;
    for (int i = 0; i < 5000; i++) begin
      if (done || err) break;
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic push(input logic wr, input logic [7:0] off, input logic [7:0] dat, input string tag);
    expWr[expCnt]   = wr;
    expOff[expCnt]  = off;
    expData[expCnt] = dat;
    expTag[expCnt]  = tag;
    expCnt++;
  endtask

  // expected access order, walked from the script table
  task automatic buildExpected(input int polls);
    expCnt = 0;
    for (int s = 0; s < NSTEP; s++) begin
      logic [1:0] kind;
      logic [7:0] off, msk;
      string tag;
      kind = SCRIPT[s][17:16];
      off  = SCRIPT[s][15:8];
      msk  = SCRIPT[s][7:0];
      tag  = (s < 2) ? "R3" : "R5";
      case (kind)
        2'd0: begin
          push(1'b0, off, 8'h00, tag);
          push(1'b1, off, initVal(off) | msk, tag);
        end
        2'd1: for (int p = 0; p < polls; p++) push(1'b0, off, 8'h00, "R4");
        default: push(1'b1, off, msk, "R6");
      endcase
    end
  endtask

  task automatic compareLog(input string tag);
    check(tag, "access count", logCnt, expCnt);
    for (int i = 0; i < expCnt && i < logCnt; i++) begin
      check(expTag[i], $sformatf("access %0d offset", i), logOff[i], expOff[i]);
      check(expTag[i], $sformatf("access %0d write flag", i), logWr[i], expWr[i]);
      if (expWr[i]) check(expTag[i], $sformatf("access %0d data", i), logData[i], expData[i]);
    end
  endtask

  task automatic checkFinalRegs();
    for (int s = 0; s < NSTEP; s++) begin
      logic [7:0] off, msk;
      off = SCRIPT[s][15:8];
      msk = SCRIPT[s][7:0];
      if (SCRIPT[s][17:16] == 2'd0)
        check((s < 2) ? "R3" : "R5", $sformatf("reg %0h value", off), mem[off[5:0]], initVal(off) | msk);
    end
    check("R6", "mode reg", mem[8'h11], 8'h04);
    check("R4", "status reg untouched", mem[3], initVal(3));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cyc;
    int snap;

    // R1: reset state
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", "done in reset", done, 0);
    check("R1", "err in reset", err, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "reqValid after reset", reqValid, 0);
    check("R1", "done after reset", done, 0);

    // main run, two-cycle bridge, calibration on third read
    lat = 2; calAfter = 3; hang = 1'b0;
    doReset();
    pulseStart();
    waitOutcome(cyc);
    check("R10", "done after script", done, 1);
    check("R10", "no error after script", err, 0);
    buildExpected(3);
    compareLog("R5");
    checkFinalRegs();
    snap = logCnt;
    repeat (10) @(negedge clk);
    check("R10", "done sticky", done, 1);
    check("R10", "no access after done", logCnt, snap);

    // R7: zero-latency bridge, calibration on first read
    lat = 0; calAfter = 1;
    doReset();
    pulseStart();
    waitOutcome(cyc);
    check("R7", "done with zero-latency bridge", done, 1);
    buildExpected(1);
    compareLog("R7");

    // R2: start while running is ignored
    lat = 1; calAfter = 2;
    doReset();
    pulseStart();
    repeat (6) @(negedge clk);
    pulseStart();
    repeat (9) @(negedge clk);
    pulseStart();
    waitOutcome(cyc);
    check("R2", "done with mid-run starts", done, 1);
    buildExpected(2);
    compareLog("R2");

    // R9: calibration never completes
    lat = 1; calAfter = 100000;
    doReset();
    pulseStart();
    waitOutcome(cyc);
    check("R9", "err on poll timeout", err, 1);
    check("R9", "no done on poll timeout", done, 0);
    check("R9", "poll reads made", (logCnt > 5) ? 1 : 0, 1);
    for (int i = 4; i < logCnt && i < LOG_MAX; i++) begin
      if (logWr[i] || logOff[i] != 8'h03)
        check("R9", $sformatf("access %0d is status read", i), {logWr[i], logOff[i]}, 9'h003);
    end
    check("R9", "later reg untouched", mem[8'h06], initVal(8'h06));
    check("R9", "mode reg untouched", mem[8'h11], initVal(8'h11));

    // R10: restart after error clears the flag and completes
    calAfter = 1;
    pulseStart();
    check("R10", "err cleared by start", err, 0);
    waitOutcome(cyc);
    check("R10", "done after restart", done, 1);
    check("R10", "err stays low after restart", err, 0);

    // R8: bridge stays busy forever
    hang = 1'b1; lat = 1;
    doReset();
    pulseStart();
    waitOutcome(cyc);
    check("R8", "err on stuck bridge", err, 1);
    check("R8", "no done on stuck bridge", done, 0);
    check("R8", "single request issued", logCnt, 1);
    check("R8", "error not before window", (cyc >= WINDOW) ? 1 : 0, 1);
    check("R8", "error soon after window", (cyc <= WINDOW + 4) ? 1 : 0, 1);
    hang = 1'b0;
    doReset();

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule